// File: doc/BRIEF.md
# Cascaded Reset Stretcher and Sequencer

This block turns the raw power-on reset of the always-on domain into a stretched always-on reset. It then carries that reset through reset synchronizers into a system clock domain, one synchronized power-on reset per power domain, and into a slow IO clock domain that runs at one quarter of the IO rate. Within each power domain it builds a lifecycle reset and a system reset. A lifecycle request pulls down both of them. A system request pulls down only the system reset. Every reset output is active-low. Every reset is asserted asynchronously and released through a two-flop synchronizer on its destination clock.

A 4-bit scan-mode input is decoded strictly. When scan mode is on, the raw power-on inputs and the requests are bypassed, and every reset output follows the scan reset pin directly, so test equipment controls the whole cascade from one pin. Only power domain 0 drives the system reset for the slow IO domain.

Top module: `rst_cascade_top`

## Requirements
- R1: Scan mode is on only when `scan_mode_i` equals exactly 4'b0110. Every other value, including 4'b1001, gives functional mode.
- R2: In scan mode every reset output equals `scan_rst_ni`, whatever the values of `por_n_i`, `lc_req_i` and `sys_req_i`.
- R3: In functional mode, while `por_n_i[0]` is low, every reset output is low.
- R4: Once `por_n_i[0]` has risen and stays high, `aon_rst_no` is still low after STRETCH always-on clock edges. It goes high after exactly STRETCH+SYNC_STAGES edges (window minimum STRETCH, maximum STRETCH+SYNC_STAGES).
- R5: If `por_n_i[0]` drops while the stretch is counting, `aon_rst_no` stays low and the count starts again from zero on the next rise.
- R6: `por_sys_rst_no[d]` goes high SYNC_STAGES system clock edges after `aon_rst_no` rises, provided `por_n_i[d]` is high. It drops at once when `por_n_i[d]` drops, and the other domain is unaffected.
- R7: `por_io4_rst_no` follows the effective always-on reset through a synchronizer on `clk_io4_i`.
- R8: `lc_req_i[d]` high drives `lc_rst_no[d]` low at once, with no clock edge needed. After the request falls, `lc_rst_no[d]` rises SYNC_STAGES edges later. The other domain is untouched.
- R9: `sys_req_i[d]` high drives `sys_rst_no[d]` low at once and leaves `lc_rst_no[d]` high. After the request falls, `sys_rst_no[d]` rises SYNC_STAGES edges later.
- R10: `sys_rst_no[d]` is never high while `lc_rst_no[d]` is low. It rises SYNC_STAGES system clock edges after `lc_rst_no[d]` rises.
- R11: `sys_io4_rst_no` is the system reset of domain 0, synchronized to `clk_io4_i`. It drops at once when `sys_rst_no[0]` drops.
- R12: A drop of `por_n_i[0]` in functional mode drives all reset outputs low at once, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_aon_i | input | 1 | Always-on clock |
| clk_sys_i | input | 1 | System clock for the per-domain resets |
| clk_io4_i | input | 1 | Slow IO clock, one quarter of the IO rate |
| por_n_i | input | NUM_PD | Raw power-on reset per power domain, active-low |
| scan_mode_i | input | 4 | Multi-bit scan-mode enable |
| scan_rst_ni | input | 1 | Scan reset, active-low |
| lc_req_i | input | NUM_PD | Lifecycle reset request per domain |
| sys_req_i | input | NUM_PD | System reset request per domain |
| aon_rst_no | output | 1 | Stretched always-on reset |
| por_io4_rst_no | output | 1 | Power-on reset in the slow IO domain |
| sys_io4_rst_no | output | 1 | Domain 0 system reset in the slow IO domain |
| por_sys_rst_no | output | NUM_PD | Synchronized power-on reset per domain |
| lc_rst_no | output | NUM_PD | Lifecycle reset per domain |
| sys_rst_no | output | NUM_PD | System reset per domain |

## Verification
The timing properties assume that the raw power-on input, the requests and the scan controls change away from clock edges. They also assume that a level stays put for at least one whole always-on cycle, so the checker's cycle count after a rise matches the cycles the synchronizer sees. The bench changes every input at the falling edge of a single 250 MHz clock. It derives the slow IO clock from that clock by a divide-by-4 counter, so every rising edge stays half a period away from any input change. Scan mode is entered only after all functional checks are done, which means the functional cycle counts never cross a scan switch.

// File: rtl/rst_cascade_pkg.sv
`timescale 1ns/1ps
package rst_cascade_pkg;

  localparam logic [3:0] SCAN_TRUE = 4'b0110;

  // strict multi-bit decode: only the exact encoding turns scan mode on
  function automatic logic scan_on(input logic [3:0] code);
    return code == SCAN_TRUE;
  endfunction

  // effective scan reset: released whenever scan mode is off
  function automatic logic scan_rst_eff(input logic scan, input logic srst_n);
    return !scan || srst_n;
  endfunction

  // output mux: scan reset overrides the functional reset in scan mode
  function automatic logic pick_rst(input logic scan, input logic srst_n,
                                    input logic func_n);
    return scan ? srst_n : func_n;
  endfunction

  // an active request pulls the reset source low
  function automatic logic req_gate(input logic src_n, input logic req);
    return src_n & ~req;
  endfunction

endpackage

// File: rtl/rst_sync_cell.sv
`timescale 1ns/1ps
module rst_sync_cell #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic q_no
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) chain <= '0;
    else          chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign q_no = chain[STAGES-1];
endmodule

// File: rtl/por_stretcher.sv
`timescale 1ns/1ps
module por_stretcher #(
  parameter int STRETCH     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic por_ni,
  output logic release_o
);
  localparam int CW = $clog2(STRETCH + 1);
  localparam logic [CW-1:0] LIMIT = CW'(STRETCH);

  logic          por_synced;
  logic [CW-1:0] cnt;

  rst_sync_cell #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i   (clk_i),
    .arst_ni (por_ni),
    .q_no    (por_synced)
  );

  // any drop of the raw input clears the count asynchronously
  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni)                         cnt <= '0;
    else if (por_synced && cnt != LIMIT) cnt <= cnt + 1'b1;
  end

  assign release_o = (cnt == LIMIT);
endmodule

// File: rtl/domain_chain.sv
`timescale 1ns/1ps
module domain_chain
  import rst_cascade_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic src_ni,
  input  logic lc_req_i,
  input  logic sys_req_i,
  output logic por_no,
  output logic lc_no,
  output logic sys_no
);
  logic lc_src_n;
  logic sys_src_n;

  rst_sync_cell #(.STAGES(SYNC_STAGES)) u_por (
    .clk_i (clk_i), .arst_ni (src_ni), .q_no (por_no)
  );

  assign lc_src_n = req_gate(por_no, lc_req_i);

  rst_sync_cell #(.STAGES(SYNC_STAGES)) u_lc (
    .clk_i (clk_i), .arst_ni (lc_src_n), .q_no (lc_no)
  );

  // the system reset is cascaded behind the lifecycle reset
  assign sys_src_n = req_gate(lc_no, sys_req_i);

  rst_sync_cell #(.STAGES(SYNC_STAGES)) u_sys (
    .clk_i (clk_i), .arst_ni (sys_src_n), .q_no (sys_no)
  );
endmodule

// File: rtl/rst_cascade_top.sv
`timescale 1ns/1ps
module rst_cascade_top
  import rst_cascade_pkg::*;
#(
  parameter int NUM_PD      = 2,
  parameter int STRETCH     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_aon_i,
  input  logic              clk_sys_i,
  input  logic              clk_io4_i,
  input  logic [NUM_PD-1:0] por_n_i,
  input  logic [3:0]        scan_mode_i,
  input  logic              scan_rst_ni,
  input  logic [NUM_PD-1:0] lc_req_i,
  input  logic [NUM_PD-1:0] sys_req_i,
  output logic              aon_rst_no,
  output logic              por_io4_rst_no,
  output logic              sys_io4_rst_no,
  output logic [NUM_PD-1:0] por_sys_rst_no,
  output logic [NUM_PD-1:0] lc_rst_no,
  output logic [NUM_PD-1:0] sys_rst_no
);
  // named internal events
  logic              scan_act;
  logic              scan_rst_n_eff;
  logic              aon_por_n;
  logic              aon_stretched;
  logic              eff_aon_n;
  logic              io4_por_func;
  logic              io4_sys_func;
  logic [NUM_PD-1:0] dom_src_n;
  logic [NUM_PD-1:0] dom_por_func;
  logic [NUM_PD-1:0] dom_lc_func;
  logic [NUM_PD-1:0] dom_sys_func;

  assign scan_act       = scan_on(scan_mode_i);
  assign scan_rst_n_eff = scan_rst_eff(scan_act, scan_rst_ni);
  // raw power-on is ignored in scan mode
  assign aon_por_n      = por_n_i[0] & ~scan_act;

  por_stretcher #(.STRETCH(STRETCH), .SYNC_STAGES(SYNC_STAGES)) u_stretch (
    .clk_i     (clk_aon_i),
    .por_ni    (aon_por_n),
    .release_o (aon_stretched)
  );

  assign aon_rst_no = pick_rst(scan_act, scan_rst_ni, aon_stretched);
  assign eff_aon_n  = aon_rst_no & scan_rst_n_eff;

  rst_sync_cell #(.STAGES(SYNC_STAGES)) u_io4_por (
    .clk_i (clk_io4_i), .arst_ni (eff_aon_n), .q_no (io4_por_func)
  );
  assign por_io4_rst_no = pick_rst(scan_act, scan_rst_ni, io4_por_func);

  for (genvar d = 0; d < NUM_PD; d++) begin : g_dom
    assign dom_src_n[d] = eff_aon_n & (scan_act | por_n_i[d]);

    domain_chain #(.SYNC_STAGES(SYNC_STAGES)) u_chain (
      .clk_i     (clk_sys_i),
      .src_ni    (dom_src_n[d]),
      .lc_req_i  (lc_req_i[d] & ~scan_act),
      .sys_req_i (sys_req_i[d] & ~scan_act),
      .por_no    (dom_por_func[d]),
      .lc_no     (dom_lc_func[d]),
      .sys_no    (dom_sys_func[d])
    );

    assign por_sys_rst_no[d] = pick_rst(scan_act, scan_rst_ni, dom_por_func[d]);
    assign lc_rst_no[d]      = pick_rst(scan_act, scan_rst_ni, dom_lc_func[d]);
    assign sys_rst_no[d]     = pick_rst(scan_act, scan_rst_ni, dom_sys_func[d]);
  end

  // only domain 0 feeds the slow IO system reset
  rst_sync_cell #(.STAGES(SYNC_STAGES)) u_io4_sys (
    .clk_i (clk_io4_i), .arst_ni (sys_rst_no[0]), .q_no (io4_sys_func)
  );
  assign sys_io4_rst_no = pick_rst(scan_act, scan_rst_ni, io4_sys_func);
endmodule

// File: rtl/rst_cascade_chk.sv
`timescale 1ns/1ps
module rst_cascade_chk #(
  parameter int NUM_PD      = 2,
  parameter int STRETCH     = 32,
  parameter int SYNC_STAGES = 2
) (
  input logic              clk_aon_i,
  input logic              clk_sys_i,
  input logic              clk_io4_i,
  input logic [NUM_PD-1:0] por_n_i,
  input logic [3:0]        scan_mode_i,
  input logic              scan_rst_ni,
  input logic [NUM_PD-1:0] lc_req_i,
  input logic [NUM_PD-1:0] sys_req_i,
  input logic              aon_rst_no,
  input logic              por_io4_rst_no,
  input logic              sys_io4_rst_no,
  input logic [NUM_PD-1:0] lc_rst_no,
  input logic [NUM_PD-1:0] sys_rst_no
);
  localparam int MAXW = STRETCH + SYNC_STAGES;
  localparam int CW   = $clog2(MAXW + 2);

  logic          scan_c;
  logic          por_func;
  logic [CW-1:0] hi_cnt;

  assign scan_c   = (scan_mode_i == 4'b0110);
  assign por_func = por_n_i[0] & ~scan_c;

  // cycles the raw always-on power-on has been high, saturating
  always_ff @(posedge clk_aon_i or negedge por_func) begin
    if (!por_func)                  hi_cnt <= '0;
    else if (hi_cnt != CW'(MAXW + 1)) hi_cnt <= hi_cnt + 1'b1;
  end

  AST_HOLD_BEFORE_MIN: assert property (@(posedge clk_aon_i) disable iff (!por_func)
    (hi_cnt < CW'(STRETCH)) |-> !aon_rst_no);                    // R4
  AST_RELEASE_BY_MAX: assert property (@(posedge clk_aon_i) disable iff (!por_func)
    (hi_cnt >= CW'(MAXW)) |-> aon_rst_no);                       // R4
  AST_SCAN_RELEASE: assert property (@(posedge clk_aon_i) disable iff (!scan_rst_ni)
    scan_c |-> (aon_rst_no && por_io4_rst_no && sys_io4_rst_no)); // R2
  AST_IO4_HELD: assert property (@(posedge clk_io4_i) disable iff (scan_c)
    !aon_rst_no |-> !por_io4_rst_no);                            // R7
  AST_IO4_SYS_HELD: assert property (@(posedge clk_io4_i) disable iff (scan_c)
    !sys_rst_no[0] |-> !sys_io4_rst_no);                         // R11

  for (genvar d = 0; d < NUM_PD; d++) begin : g_dchk
    AST_LC_REQ_HOLDS: assert property (@(posedge clk_sys_i) disable iff (scan_c)
      lc_req_i[d] |-> (!lc_rst_no[d] && !sys_rst_no[d]));        // R8
    AST_SYS_REQ_HOLDS: assert property (@(posedge clk_sys_i) disable iff (scan_c)
      sys_req_i[d] |-> !sys_rst_no[d]);                          // R9
    AST_SYS_AFTER_LC: assert property (@(posedge clk_sys_i) disable iff (scan_c)
      !lc_rst_no[d] |-> !sys_rst_no[d]);                         // R10
  end
endmodule

bind rst_cascade_top rst_cascade_chk #(
  .NUM_PD(NUM_PD), .STRETCH(STRETCH), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk_aon_i      (clk_aon_i),
  .clk_sys_i      (clk_sys_i),
  .clk_io4_i      (clk_io4_i),
  .por_n_i        (por_n_i),
  .scan_mode_i    (scan_mode_i),
  .scan_rst_ni    (scan_rst_ni),
  .lc_req_i       (lc_req_i),
  .sys_req_i      (sys_req_i),
  .aon_rst_no     (aon_rst_no),
  .por_io4_rst_no (por_io4_rst_no),
  .sys_io4_rst_no (sys_io4_rst_no),
  .lc_rst_no      (lc_rst_no),
  .sys_rst_no     (sys_rst_no)
);

// File: tb/tb_rst_cascade_top.sv
`timescale 1ns/1ps
module tb_rst_cascade_top;
  localparam int NUM_PD = 2;
  localparam int S      = 32;
  localparam int SY     = 2;

  logic              clk = 1'b0;
  logic [1:0]        div = '0;
  logic              clk_io4;
  logic [NUM_PD-1:0] por_n = '0;
  logic [3:0]        smode = 4'b1001;
  logic              srst_n = 1'b0;
  logic [NUM_PD-1:0] lc_req = '0;
  logic [NUM_PD-1:0] sys_req = '0;
  logic              aon_n, pio4_n, sio4_n;
  logic [NUM_PD-1:0] psys_n, lc_n, sys_n;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) div <= div + 1'b1;
  assign clk_io4 = div[1];

  rst_cascade_top #(.NUM_PD(NUM_PD), .STRETCH(S), .SYNC_STAGES(SY)) dut (
    .clk_aon_i (clk), .clk_sys_i (clk), .clk_io4_i (clk_io4),
    .por_n_i (por_n), .scan_mode_i (smode), .scan_rst_ni (srst_n),
    .lc_req_i (lc_req), .sys_req_i (sys_req),
    .aon_rst_no (aon_n), .por_io4_rst_no (pio4_n), .sys_io4_rst_no (sio4_n),
    .por_sys_rst_no (psys_n), .lc_rst_no (lc_n), .sys_rst_no (sys_n)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // {scan_mode[3:0], scan_rst_n, por_n[0], expected level of every output}
  localparam logic [6:0] VEC [8] = '{
    7'b0110_1_0_1, 7'b0110_0_1_0, 7'b0110_1_1_1, 7'b1001_1_0_0,
    7'b0111_1_0_0, 7'b1110_1_0_0, 7'b0100_1_0_0, 7'b1111_1_0_0
  };

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    tick(5);
    // R3 reset state
    chk("R3 aon", aon_n, 1'b0);   chk("R3 io4", pio4_n, 1'b0);
    chk("R3 psys0", psys_n[0], 1'b0); chk("R3 lc1", lc_n[1], 1'b0);
    chk("R3 sys0", sys_n[0], 1'b0); chk("R3 sio4", sio4_n, 1'b0);

    // R5 restart during count
    por_n[1] = 1'b1; por_n[0] = 1'b1;
    tick(10);
    por_n[0] = 1'b0; #1;
    chk("R5 aon held", aon_n, 1'b0);
    @(negedge clk);
    por_n[0] = 1'b1;
    tick(S + SY - 1);
    chk("R5 aon not early after restart", aon_n, 1'b0);
    tick(1);
    chk("R5 R4 aon released at max", aon_n, 1'b1);

    // R6 / R10 cascade timing in the system domain
    tick(1); chk("R6 psys0 early", psys_n[0], 1'b0);
    tick(1); chk("R6 psys0", psys_n[0], 1'b1); chk("R6 psys1", psys_n[1], 1'b1);
    tick(1); chk("R8 lc0 early", lc_n[0], 1'b0);
    tick(1); chk("R8 lc0", lc_n[0], 1'b1);
    tick(1); chk("R10 sys0 early", sys_n[0], 1'b0);
    tick(1); chk("R10 sys0", sys_n[0], 1'b1); chk("R10 sys1", sys_n[1], 1'b1);
    tick(40);
    chk("R7 io4 por", pio4_n, 1'b1);
    chk("R11 io4 sys", sio4_n, 1'b1);

    // R8 lifecycle request on domain 1
    lc_req[1] = 1'b1; #1;
    chk("R8 lc1 async", lc_n[1], 1'b0); chk("R8 sys1 cascade", sys_n[1], 1'b0);
    chk("R8 lc0 untouched", lc_n[0], 1'b1); chk("R8 psys1 untouched", psys_n[1], 1'b1);
    @(negedge clk); lc_req[1] = 1'b0;
    tick(SY - 1); chk("R8 lc1 early", lc_n[1], 1'b0);
    tick(1);      chk("R8 lc1 release", lc_n[1], 1'b1);
    tick(SY - 1); chk("R10 sys1 early", sys_n[1], 1'b0);
    tick(1);      chk("R10 sys1 release", sys_n[1], 1'b1);

    // R9 system request on domain 0, R11 slow IO follows
    sys_req[0] = 1'b1; #1;
    chk("R9 sys0 async", sys_n[0], 1'b0); chk("R9 lc0 kept", lc_n[0], 1'b1);
    chk("R11 sio4 async", sio4_n, 1'b0);  chk("R9 sys1 kept", sys_n[1], 1'b1);
    @(negedge clk); sys_req[0] = 1'b0;
    tick(SY - 1); chk("R9 sys0 early", sys_n[0], 1'b0);
    tick(1);      chk("R9 sys0 release", sys_n[0], 1'b1);
    tick(40);     chk("R11 sio4 release", sio4_n, 1'b1);

    // R6 per-domain power-on drop
    por_n[1] = 1'b0; #1;
    chk("R6 psys1 drop", psys_n[1], 1'b0); chk("R6 sys1 drop", sys_n[1], 1'b0);
    chk("R6 psys0 kept", psys_n[0], 1'b1); chk("R6 aon kept", aon_n, 1'b1);
    @(negedge clk); por_n[1] = 1'b1;

    // R12 always-on drop asserts everything at once
    tick(3);
    por_n[0] = 1'b0; #1;
    chk("R12 aon", aon_n, 1'b0); chk("R12 io4", pio4_n, 1'b0);
    chk("R12 lc0", lc_n[0], 1'b0); chk("R12 sys1", sys_n[1], 1'b0);
    chk("R12 sio4", sio4_n, 1'b0);

    // R1 / R2 scan decode vectors
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      smode = VEC[i][6:3]; srst_n = VEC[i][2]; por_n[0] = VEC[i][1];
      #1;
      chk($sformatf("R1 R2 vec%0d aon", i), aon_n, VEC[i][0]);
      chk($sformatf("R2 vec%0d io4", i), pio4_n, VEC[i][0]);
      chk($sformatf("R2 vec%0d lc1", i), lc_n[1], VEC[i][0]);
      chk($sformatf("R2 vec%0d sys0", i), sys_n[0], VEC[i][0]);
    end

    // R2 requests ignored in scan mode
    @(negedge clk);
    smode = 4'b0110; srst_n = 1'b1; lc_req = '1; sys_req = '1; por_n = '0; #1;
    chk("R2 lc0 req ignored", lc_n[0], 1'b1);
    chk("R2 sys1 req ignored", sys_n[1], 1'b1);
    chk("R2 psys1 por ignored", psys_n[1], 1'b1);

    // R1 back to functional with power-on low
    @(negedge clk); smode = 4'b1001; lc_req = '0; sys_req = '0; #1;
    chk("R1 R3 functional aon", aon_n, 1'b0);
    chk("R3 functional sys0", sys_n[0], 1'b0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule